// File: doc/BRIEF.md
# T1/J1 Yellow Alarm Inserter

This block sits in a T1/J1 transmit path and overlays the remote (yellow) alarm signature onto the serial bit stream. It receives one line bit per clock along with timing markers from the upstream frame generator. The markers give the frame number within the multiframe, a flag for the framing bit, the bit position inside the current channel byte, and a flag for a framing bit that belongs to the data link. The block delays the bit and the markers by one register stage, and changes the bit only where the selected alarm signature requires it.

Two selects choose the signature. One chooses between superframe and extended superframe. The other chooses between T1 and J1 alarm behaviour. With superframe and T1, the second bit of every channel byte is driven low. With superframe and J1, the framing bit of frame 12 is driven high. With extended superframe, a 16-bit code word is sent MSB first, one bit per data-link slot: 0xFF00 for T1 and 0xFFFF for J1. The selects are sampled only at the multiframe boundary. A data-link word that has started is always sent to its end.

Top module: `t1j1_yellow_ins`

## Requirements
- R1: When the alarm request is low and no data-link word is in progress, out_bit equals the in_bit of the previous cycle.
- R2: out_fbit, out_frame, out_bitpos and out_dl equal the matching inputs of the previous cycle.
- R3: With the T1 superframe signature and the request high, a non-framing bit at in_bitpos 1 (position 0 is the first bit of the channel byte) is output as 0. All other bits pass through.
- R4: With the J1 superframe signature and the request high, the framing bit of frame 12 (frames are numbered from 1) is output as 1. All other bits pass through.
- R5: With the T1 extended-superframe signature active, each data-link slot (in_fbit and in_dl both high) outputs the next bit of 0xFF00, MSB first.
- R6: With the J1 extended-superframe signature active, each data-link slot outputs the next bit of 0xFFFF, MSB first.
- R7: A request raised while no word is in progress starts the code word at its MSB in the next data-link slot.
- R8: If the request drops in the middle of a word, the remaining bits of that word are still sent. After that the stream passes through.
- R9: The selects are captured at the framing bit of frame 1, and they already govern that bit. Changes made at any other time have no effect until that point.
- R10: During reset all outputs are 0. After reset the T1 superframe signature is in force until the first framing bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_req | input | 1 | Yellow alarm request |
| sel_j1 | input | 1 | 0 selects T1 behaviour, 1 selects J1 behaviour |
| sel_esf | input | 1 | 0 selects superframe, 1 selects extended superframe |
| in_bit | input | 1 | Transmit line bit |
| in_fbit | input | 1 | High on a framing bit |
| in_frame | input | FW | Frame number in the multiframe, from 1 |
| in_bitpos | input | PW | Bit position inside the channel byte, 0 is first |
| in_dl | input | 1 | High on a framing bit that carries the data link |
| out_bit | output | 1 | Line bit with the alarm applied |
| out_fbit | output | 1 | Delayed in_fbit |
| out_frame | output | FW | Delayed in_frame |
| out_bitpos | output | PW | Delayed in_bitpos |
| out_dl | output | 1 | Delayed in_dl |

## Verification
Full multiframes of pseudo-random payload are sent in all four select combinations. For each, the alarm is off for some stretches and on for others, so any forcing in the wrong place or in the wrong mode shows up as a mismatch. The request is dropped halfway through a data-link word, and this separates a word that runs to its end from one cut short. The selects are also changed in the middle of a multiframe, which shows that they take effect exactly at the next frame-1 framing bit. Right after reset, frames start away from the boundary, which exposes the reset configuration.

// File: rtl/t1j1_yellow_ins.sv
module t1j1_yellow_ins #(
  parameter int FW = 5,
  parameter int PW = 3,
  parameter int WL = 16,
  parameter logic [FW-1:0] ALARM_FRAME = 12,
  parameter logic [PW-1:0] ALARM_POS = 1,
  parameter logic [WL-1:0] T1_WORD = 16'hFF00,
  parameter logic [WL-1:0] J1_WORD = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alarm_req,
  input  logic          sel_j1,
  input  logic          sel_esf,
  input  logic          in_bit,
  input  logic          in_fbit,
  input  logic [FW-1:0] in_frame,
  input  logic [PW-1:0] in_bitpos,
  input  logic          in_dl,
  output logic          out_bit,
  output logic          out_fbit,
  output logic [FW-1:0] out_frame,
  output logic [PW-1:0] out_bitpos,
  output logic          out_dl
);
  localparam int CW = $clog2(WL);
  localparam logic [CW-1:0] TOP = CW'(WL - 1);

  logic          cfg_j1_q, cfg_esf_q;
  logic [CW-1:0] cnt_q;
  logic          nxt;

  wire          bnd     = in_fbit && (in_frame == FW'(1));
  wire          j1      = bnd ? sel_j1  : cfg_j1_q;
  wire          esf     = bnd ? sel_esf : cfg_esf_q;
  wire          dl_slot = esf && in_fbit && in_dl;
  wire          busy    = alarm_req || (cnt_q != '0);
  wire [WL-1:0] word    = j1 ? J1_WORD : T1_WORD;
  wire          dl_bit  = word[TOP - cnt_q];

  always_comb begin
    nxt = in_bit;
    if (!esf) begin
      if (alarm_req && !j1 && !in_fbit && in_bitpos == ALARM_POS) nxt = 1'b0;
      if (alarm_req && j1 && in_fbit && in_frame == ALARM_FRAME)  nxt = 1'b1;
    end else if (dl_slot && busy) begin
      nxt = dl_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_j1_q   <= 1'b0;
      cfg_esf_q  <= 1'b0;
      cnt_q      <= '0;
      out_bit    <= 1'b0;
      out_fbit   <= 1'b0;
      out_frame  <= '0;
      out_bitpos <= '0;
      out_dl     <= 1'b0;
    end else begin
      if (bnd) begin
        cfg_j1_q  <= sel_j1;
        cfg_esf_q <= sel_esf;
      end
      if (!esf)                cnt_q <= '0;
      else if (dl_slot && busy) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
      out_bit    <= nxt;
      out_fbit   <= in_fbit;
      out_frame  <= in_frame;
      out_bitpos <= in_bitpos;
      out_dl     <= in_dl;
    end
  end
endmodule

module t1j1_yellow_ins_chk #(
  parameter int FW = 5,
  parameter int PW = 3,
  parameter int CW = 4,
  parameter logic [FW-1:0] ALARM_FRAME = 12,
  parameter logic [PW-1:0] ALARM_POS = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alarm_req,
  input logic          in_bit,
  input logic          in_fbit,
  input logic [FW-1:0] in_frame,
  input logic [PW-1:0] in_bitpos,
  input logic          in_dl,
  input logic          out_bit,
  input logic          out_fbit,
  input logic [FW-1:0] out_frame,
  input logic [PW-1:0] out_bitpos,
  input logic          out_dl,
  input logic          cfg_j1_q,
  input logic          cfg_esf_q,
  input logic [CW-1:0] cnt_q
);
  wire nb = !(in_fbit && in_frame == FW'(1));

  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_req && cnt_q == '0) |=> out_bit == $past(in_bit));

  a_r2_markers: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_fbit == $past(in_fbit) && out_frame == $past(in_frame) &&
              out_bitpos == $past(in_bitpos) && out_dl == $past(in_dl)));

  a_r3_t1sf_force: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_req && !cfg_j1_q && !cfg_esf_q && !in_fbit && in_bitpos == ALARM_POS) |=> !out_bit);

  a_r4_j1sf_fbit: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_req && cfg_j1_q && !cfg_esf_q && in_fbit && in_frame == ALARM_FRAME) |=> out_bit);

  a_r5_t1esf_low: assert property (@(posedge clk) disable iff (!rst_n)
    (nb && cfg_esf_q && !cfg_j1_q && in_fbit && in_dl && cnt_q[CW-1]) |=> !out_bit);

  a_r6_j1esf_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (nb && cfg_esf_q && cfg_j1_q && in_fbit && in_dl && (alarm_req || cnt_q != '0)) |=> out_bit);

  a_r8_word_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (nb && cfg_esf_q && in_fbit && in_dl && cnt_q != '0) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

bind t1j1_yellow_ins t1j1_yellow_ins_chk #(
  .FW(FW), .PW(PW), .CW(CW), .ALARM_FRAME(ALARM_FRAME), .ALARM_POS(ALARM_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_req(alarm_req), .in_bit(in_bit),
  .in_fbit(in_fbit), .in_frame(in_frame), .in_bitpos(in_bitpos), .in_dl(in_dl),
  .out_bit(out_bit), .out_fbit(out_fbit), .out_frame(out_frame),
  .out_bitpos(out_bitpos), .out_dl(out_dl),
  .cfg_j1_q(cfg_j1_q), .cfg_esf_q(cfg_esf_q), .cnt_q(cnt_q)
);

// File: tb/test_t1j1_yellow_ins.sv
`timescale 1ns/1ps
module test_t1j1_yellow_ins;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_req = 1'b0, sel_j1 = 1'b0, sel_esf = 1'b0;
  logic       in_bit = 1'b0, in_fbit = 1'b0, in_dl = 1'b0;
  logic [4:0] in_frame = '0;
  logic [2:0] in_bitpos = '0;
  logic       out_bit, out_fbit, out_dl;
  logic [4:0] out_frame;
  logic [2:0] out_bitpos;

  int checks = 0, fails = 0;
  int bitno = 0, fr = 1;
  logic gen_esf = 1'b0;
  logic m_j1 = 1'b0, m_esf = 1'b0;
  int   m_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  string phase = "";

  always #4 clk = ~clk;

  t1j1_yellow_ins i_t1j1_yellow_ins (
    .clk(clk), .rst_n(rst_n), .alarm_req(alarm_req), .sel_j1(sel_j1), .sel_esf(sel_esf),
    .in_bit(in_bit), .in_fbit(in_fbit), .in_frame(in_frame), .in_bitpos(in_bitpos), .in_dl(in_dl),
    .out_bit(out_bit), .out_fbit(out_fbit), .out_frame(out_frame),
    .out_bitpos(out_bitpos), .out_dl(out_dl));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (frame %0d bit %0d)", tag, act, exp, fr, bitno);
    end
  endtask

  task automatic step();
    logic fb, dl, d, e, bnd, busy;
    logic [2:0] pos;
    logic [15:0] w;
    string tag;
    if (bitno == 0 && fr == 1) gen_esf = sel_esf;
    fb  = (bitno == 0);
    pos = fb ? 3'd0 : 3'((bitno - 1) % 8);
    dl  = gen_esf && fb && (fr % 2 == 1);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    d = lfsr[0];
    bnd = fb && fr == 1;
    if (bnd) begin m_j1 = sel_j1; m_esf = sel_esf; end
    busy = alarm_req || m_cnt != 0;
    e = d; tag = "R1";
    if (!m_esf) begin
      if (alarm_req && !m_j1 && !fb && pos == 3'd1) begin e = 1'b0; tag = "R3"; end
      if (alarm_req && m_j1 && fb && fr == 12) begin e = 1'b1; tag = "R4"; end
      m_cnt = 0;
    end else if (dl && busy) begin
      w = m_j1 ? 16'hFFFF : 16'hFF00;
      e = w[15 - m_cnt];
      tag = m_j1 ? "R6" : "R5";
      if (!alarm_req) tag = {tag, "/R8"};
      else if (m_cnt == 0) tag = {tag, "/R7"};
      m_cnt = (m_cnt + 1) % 16;
    end
    in_bit = d; in_fbit = fb; in_frame = 5'(fr); in_bitpos = pos; in_dl = dl;
    @(negedge clk);
    chk(out_bit == e, {phase, " ", tag}, int'(out_bit), int'(e));
    chk(out_fbit == fb && out_frame == 5'(fr) && out_bitpos == pos && out_dl == dl,
        {phase, " R2"}, {out_fbit, out_frame, out_bitpos, out_dl}, {fb, 5'(fr), pos, dl});
    bitno++;
    if (bitno == 193) begin
      bitno = 0;
      fr++;
      if (fr > (gen_esf ? 24 : 12)) fr = 1;
    end
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * 193; i++) step();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    sel_j1 = 1'b1; alarm_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_bit == 0 && out_fbit == 0 && out_frame == 0 && out_bitpos == 0 && out_dl == 0,
        "R10 reset", {out_bit, out_fbit, out_frame, out_bitpos, out_dl}, 0);
    rst_n = 1'b1;
    fr = 2; phase = "R10";
    run_frames(11);
    phase = "J1SF"; run_frames(12);
    alarm_req = 0; phase = "R1 idle"; run_frames(12);
    sel_j1 = 0; alarm_req = 1; phase = "T1SF"; run_frames(12);
    run_frames(4);
    sel_j1 = 1; phase = "R9 j1 change"; run_frames(12);
    sel_j1 = 0; sel_esf = 1; phase = "R9 esf change"; run_frames(8);
    phase = "T1ESF"; run_frames(24);
    run_frames(11);
    bitno = bitno; alarm_req = 0; phase = "R8 drop"; run_frames(13 + 24);
    alarm_req = 1; phase = "R7 restart"; run_frames(3);
    sel_j1 = 1; phase = "J1ESF"; run_frames(21 + 24);
    alarm_req = 0; phase = "R8 j1"; run_frames(24);
    sel_esf = 0; alarm_req = 1; phase = "R9 back to SF"; run_frames(24 + 12);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule